// File: doc/BRIEF.md
# Data Request and Lost-Data Monitor

This block sits between a tape controller's two-stage word buffer and the host computer's programmed data channel. It keeps a single flag asking the computer for the next word. It detects the two ways a word can be lost: a tape character arrives while the buffer cannot take it, or a character is due to go to tape while the output stage is empty. It also guards the first word of a write record. All strobes arrive as levels, and the block finds their edges against its own clock.

A rising transfer pulse raises the request, and so does the start of write motion. Any computer strobe or termination condition drops it. Lost data is sticky and also holds the request down. The block builds the tape write strobe from the write clock or from the phase-encode request, according to the density select. It flags the first word of a record and emits a one-cycle lockout when the output stage is still empty at the first early write strobe.

Top module: `word_req_monitor`

## Requirements
- R1: A rising edge of `xfer_pulse` sets `data_req` one clock later when `buf_mode` is low. While `buf_mode` is high, `data_req` cannot be set.
- R2: A rising edge of `wm_start` sets `data_req` one clock later when `buf_mode` is low.
- R3: `data_req` is cleared at the next clock when any of these is high: `cpu_rd_stb`, `cpu_wr_stb`, `eor_seq`, `fm_det`, `eop` or `lost_data`. A clear wins over a set in the same cycle.
- R4: On a rising edge of `tape_rd_stb` while `read_motion` and `buf1_full` are high, and while `buf_mode` or `last_word` is high, `lost_data` is set one clock later. With both `buf_mode` and `last_word` low, it is not set.
- R5: On a rising edge of `tape_wr_stb` with `buf_mode` high and `buf2_full` low, `lost_data` is set one clock later. With `buf2_full` high, or with `buf_mode` low, it is not set.
- R6: Once set, `lost_data` stays high until a clock with `rst_n` low.
- R7: `tape_wr_stb` is combinational. It equals `pe_req` when `hi_density` is 1 and `wr_clk` when `hi_density` is 0, and it is 0 whenever `write_motion` is low.
- R8: A rising edge of `wm_start` sets `first_word`. The next falling edge of `wr_clk` clears it.
- R9: After a `wm_start` edge, the first rising edge of `early_wds` gives a `lockout` pulse one clock long if `buf2_full` is low, and no pulse if `buf2_full` is high. Later `early_wds` edges give no pulse until the next `wm_start` edge.
- R10: A clock with `rst_n` low clears `data_req`, `lost_data`, `first_word` and `lockout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_mode | input | 1 | Buffered I/O transfer mode |
| xfer_pulse | input | 1 | Stage-1 to stage-2 transfer timing |
| wm_start | input | 1 | Write-motion start strobe |
| cpu_rd_stb | input | 1 | Computer read strobe |
| cpu_wr_stb | input | 1 | Computer write strobe |
| eor_seq | input | 1 | End-of-record sequence active |
| fm_det | input | 1 | File mark detected |
| eop | input | 1 | End of operation |
| last_word | input | 1 | Last word of the transfer |
| buf1_full | input | 1 | Buffer stage 1 holds valid data |
| buf2_full | input | 1 | Buffer stage 2 output is valid |
| read_motion | input | 1 | Tape read motion active |
| write_motion | input | 1 | Tape write motion active |
| tape_rd_stb | input | 1 | Tape read data strobe |
| wr_clk | input | 1 | Write clock, lower density |
| pe_req | input | 1 | Phase-encode write request |
| hi_density | input | 1 | 1 selects 1600 bpi |
| early_wds | input | 1 | Early write data strobe |
| data_req | output | 1 | Request for the next computer word |
| lost_data | output | 1 | Sticky data-loss flag |
| first_word | output | 1 | First word of the record not yet written |
| lockout | output | 1 | One-cycle late-first-word pulse |
| tape_wr_stb | output | 1 | Tape write data strobe |

## Verification
A set and a clear in the same cycle is driven on purpose. A design that let the set win would leave the request standing after end of operation. The write-side loss is tried with unbuffered transfers and with a full output stage, where it must stay quiet. A design that skipped either gate would flag loss on a legal end of record. The read-side loss is tried with neither buffered mode nor last word active, and a missing OR term would show there. Lockout is driven by a second early strobe and by a full output stage. A missing arming flag would pulse on every strobe. A lost-data flag that was not sticky would fall once the loss condition went away, and a request that ignored lost data would stand again after the next transfer edge.

// File: rtl/word_req_pkg.sv
// Shared definitions for the data request monitor.
// Assumes every event source is a level whose edges are taken on clk.
package word_req_pkg;
    // Event bit positions in the edge detector bank
    localparam int unsigned EV_XFER  = 0;
    localparam int unsigned EV_START = 1;
    localparam int unsigned EV_RDS   = 2;
    localparam int unsigned EV_WDS   = 3;
    localparam int unsigned EV_WCLK  = 4;
    localparam int unsigned EV_EARLY = 5;
    localparam int unsigned NUM_EV   = 6;

    // Conditions that drop the data request
    typedef struct packed {
        logic cpu_rd;
        logic cpu_wr;
        logic eor;
        logic fm;
        logic eop;
        logic lost;
    } clr_src_t;
endpackage

// File: rtl/edge_bank.sv
// Rising and falling edge detection for a vector of level inputs.
// Assumes inputs are already synchronous to clk. The history register is
// not reset, so a level held through reset gives no edge afterwards.
module edge_bank #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    // Keep the previous sample of every input
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Compare the current level with the last sample
        always_comb begin
            rise[i] = lvl[i] & ~prev_q[i];
            fall[i] = ~lvl[i] & prev_q[i];
        end
    end
endmodule

// File: rtl/req_ctrl.sv
// Holds the request for the next computer word.
// Assumes the set events are single-cycle edge pulses. Any clear source
// overrides a set, and buffered mode blocks both set events.
module req_ctrl
    import word_req_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     buf_mode,
    input  logic     set_xfer,
    input  logic     set_start,
    input  clr_src_t clr,
    output logic     req
);
    logic any_clr;

    // Collapse the clear sources
    always_comb any_clr = |clr;

    // Request flag: clear first, then a set when not buffered
    always_ff @(posedge clk) begin
        if (!rst_n || any_clr)
            req <= 1'b0;
        else if (!buf_mode && (set_xfer || set_start))
            req <= 1'b1;
    end

    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr.eop || clr.lost || clr.cpu_rd) |=> !req);
    assert_buf_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && !req) |=> !req);
endmodule

// File: rtl/loss_det.sv
// Sticky detection of lost data on the read and the write path.
// Assumes the strobe inputs are edge pulses. The write strobe edge only
// happens during write motion.
module loss_det (
    input  logic clk,
    input  logic rst_n,
    input  logic read_motion,
    input  logic buf_mode,
    input  logic last_word,
    input  logic buf1_full,
    input  logic buf2_full,
    input  logic rds_rise,
    input  logic wds_rise,
    output logic lost
);
    logic rd_loss;
    logic wr_loss;

    // Read: a tape character arrives while stage 1 is still occupied
    always_comb rd_loss = read_motion && rds_rise && buf1_full && (buf_mode || last_word);
    // Write: a character is due while the output stage is empty, buffered only
    always_comb wr_loss = wds_rise && buf_mode && !buf2_full;

    // Sticky flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            lost <= 1'b0;
        else if (rd_loss || wr_loss)
            lost <= 1'b1;
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> lost);
    assert_quiet_unbuf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lost && !read_motion && !buf_mode) |=> !lost);
    assert_read_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lost && !buf1_full && !wds_rise) |=> !lost);
endmodule

// File: rtl/first_word_ctl.sv
// Tracks the first word of a write record and raises the late-word lockout.
// Assumes the event inputs are edge pulses. An arming flag limits the
// lockout test to the first early strobe after each motion start.
module first_word_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rise,
    input  logic wclk_fall,
    input  logic early_rise,
    input  logic buf2_full,
    output logic first_word,
    output logic lockout
);
    logic armed_q;

    // First-word flag: set by start, cleared by a write clock fall
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_word <= 1'b0;
        else if (start_rise)
            first_word <= 1'b1;
        else if (wclk_fall)
            first_word <= 1'b0;
    end

    // Armed from start until the first early strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (start_rise)
            armed_q <= 1'b1;
        else if (early_rise)
            armed_q <= 1'b0;
    end

    // Lockout pulse when the first early strobe finds stage 2 empty
    always_ff @(posedge clk) begin
        if (!rst_n)
            lockout <= 1'b0;
        else
            lockout <= armed_q && early_rise && !buf2_full;
    end

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && !start_rise) |=> !lockout);
    assert_needs_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout) |-> !$past(buf2_full));
    assert_first_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (first_word && wclk_fall && !start_rise) |=> !first_word);
endmodule

// File: rtl/word_req_monitor.sv
// Top of the data request and lost-data monitor.
// Builds the tape write strobe, takes the edges of every event level and
// connects the request, loss and first-word controllers.
module word_req_monitor
    import word_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic buf_mode,
    input  logic xfer_pulse,
    input  logic wm_start,
    input  logic cpu_rd_stb,
    input  logic cpu_wr_stb,
    input  logic eor_seq,
    input  logic fm_det,
    input  logic eop,
    input  logic last_word,
    input  logic buf1_full,
    input  logic buf2_full,
    input  logic read_motion,
    input  logic write_motion,
    input  logic tape_rd_stb,
    input  logic wr_clk,
    input  logic pe_req,
    input  logic hi_density,
    input  logic early_wds,
    output logic data_req,
    output logic lost_data,
    output logic first_word,
    output logic lockout,
    output logic tape_wr_stb
);
    logic [NUM_EV-1:0] ev_lvl;
    logic [NUM_EV-1:0] ev_rise;
    logic [NUM_EV-1:0] ev_fall;
    clr_src_t          clr;

    // Tape write strobe: density picks the source, gated by write motion
    always_comb tape_wr_stb = write_motion && (hi_density ? pe_req : wr_clk);

    // Gather the event levels into one vector
    always_comb begin
        ev_lvl           = '0;
        ev_lvl[EV_XFER]  = xfer_pulse;
        ev_lvl[EV_START] = wm_start;
        ev_lvl[EV_RDS]   = tape_rd_stb;
        ev_lvl[EV_WDS]   = tape_wr_stb;
        ev_lvl[EV_WCLK]  = wr_clk;
        ev_lvl[EV_EARLY] = early_wds;
    end

    // Collect the request clear sources
    always_comb begin
        clr.cpu_rd = cpu_rd_stb;
        clr.cpu_wr = cpu_wr_stb;
        clr.eor    = eor_seq;
        clr.fm     = fm_det;
        clr.eop    = eop;
        clr.lost   = lost_data;
    end

    edge_bank #(.W(NUM_EV)) u_edges (
        .clk  (clk),
        .lvl  (ev_lvl),
        .rise (ev_rise),
        .fall (ev_fall)
    );

    req_ctrl u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_mode  (buf_mode),
        .set_xfer  (ev_rise[EV_XFER]),
        .set_start (ev_rise[EV_START]),
        .clr       (clr),
        .req       (data_req)
    );

    loss_det u_loss (
        .clk         (clk),
        .rst_n       (rst_n),
        .read_motion (read_motion),
        .buf_mode    (buf_mode),
        .last_word   (last_word),
        .buf1_full   (buf1_full),
        .buf2_full   (buf2_full),
        .rds_rise    (ev_rise[EV_RDS]),
        .wds_rise    (ev_rise[EV_WDS]),
        .lost        (lost_data)
    );

    first_word_ctl u_first (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rise (ev_rise[EV_START]),
        .wclk_fall  (ev_fall[EV_WCLK]),
        .early_rise (ev_rise[EV_EARLY]),
        .buf2_full  (buf2_full),
        .first_word (first_word),
        .lockout    (lockout)
    );

    assert_wds_motion_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tape_wr_stb |-> write_motion);
    assert_lost_blocks_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lost_data) |-> !data_req);
endmodule

// File: tb/word_req_monitor_tb.sv
module word_req_monitor_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_mode = 0, xfer_pulse = 0, wm_start = 0, cpu_rd_stb = 0, cpu_wr_stb = 0;
    logic eor_seq = 0, fm_det = 0, eop = 0, last_word = 0, buf1_full = 0, buf2_full = 0;
    logic read_motion = 0, write_motion = 0, tape_rd_stb = 0, wr_clk = 0, pe_req = 0;
    logic hi_density = 0, early_wds = 0;
    logic data_req, lost_data, first_word, lockout, tape_wr_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    word_req_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .xfer_pulse(xfer_pulse),
        .wm_start(wm_start), .cpu_rd_stb(cpu_rd_stb), .cpu_wr_stb(cpu_wr_stb),
        .eor_seq(eor_seq), .fm_det(fm_det), .eop(eop), .last_word(last_word),
        .buf1_full(buf1_full), .buf2_full(buf2_full), .read_motion(read_motion),
        .write_motion(write_motion), .tape_rd_stb(tape_rd_stb), .wr_clk(wr_clk),
        .pe_req(pe_req), .hi_density(hi_density), .early_wds(early_wds),
        .data_req(data_req), .lost_data(lost_data), .first_word(first_word),
        .lockout(lockout), .tape_wr_stb(tape_wr_stb)
    );

    // wm, hd, wclk, pe, expected strobe (R7)
    typedef struct packed {
        logic wm;
        logic hd;
        logic wc;
        logic pe;
        logic exp;
    } vec_t;
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Advance one clock and settle past the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
    endtask

    // Make a fresh xfer rising edge and return with request set
    task automatic raise_req();
        xfer_pulse = 1'b0;
        tick();
        xfer_pulse = 1'b1;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        // R10 reset state
        chk("R10 data_req reset", data_req, 1'b0);
        chk("R10 lost_data reset", lost_data, 1'b0);
        chk("R10 first_word reset", first_word, 1'b0);
        chk("R10 lockout reset", lockout, 1'b0);
        rst_n = 1'b1;
        tick();

        // R7 strobe source table, combinational
        for (int i = 0; i < 8; i++) begin
            write_motion = VECS[i].wm;
            hi_density   = VECS[i].hd;
            wr_clk       = VECS[i].wc;
            pe_req       = VECS[i].pe;
            #1;
            chk("R7 tape_wr_stb", tape_wr_stb, VECS[i].exp);
        end
        write_motion = 0; hi_density = 0; wr_clk = 0; pe_req = 0;
        tick();
        do_reset();
        tick();

        // R1 set by transfer edge, R3 clear by read strobe
        raise_req();
        chk("R1 xfer sets req", data_req, 1'b1);
        cpu_rd_stb = 1'b1;
        tick();
        cpu_rd_stb = 1'b0;
        chk("R3 cpu_rd clears", data_req, 1'b0);

        // R1 blocked in buffered mode
        buf_mode = 1'b1;
        raise_req();
        chk("R1 buf_mode blocks", data_req, 1'b0);
        buf_mode = 1'b0;

        // R2 start sets req, R8 sets first word
        wm_start = 1'b1;
        tick();
        wm_start = 1'b0;
        chk("R2 start sets req", data_req, 1'b1);
        chk("R8 start sets first_word", first_word, 1'b1);
        cpu_wr_stb = 1'b1;
        tick();
        cpu_wr_stb = 1'b0;
        chk("R3 cpu_wr clears", data_req, 1'b0);

        // R3 remaining clear sources
        for (int k = 0; k < 3; k++) begin
            raise_req();
            chk("R3 req before clear", data_req, 1'b1);
            eor_seq = (k == 0); fm_det = (k == 1); eop = (k == 2);
            tick();
            eor_seq = 0; fm_det = 0; eop = 0;
            chk("R3 eor/fm/eop clears", data_req, 1'b0);
        end

        // R3 clear wins over simultaneous set
        xfer_pulse = 1'b0;
        tick();
        xfer_pulse = 1'b1; eop = 1'b1;
        tick();
        eop = 1'b0;
        chk("R3 clear beats set", data_req, 1'b0);
        xfer_pulse = 1'b0;

        // R8 first rising wr_clk keeps, falling clears
        wr_clk = 1'b1;
        tick();
        chk("R8 held on clock rise", first_word, 1'b1);
        wr_clk = 1'b0;
        tick();
        chk("R8 cleared on clock fall", first_word, 1'b0);

        // R9 lockout on first early strobe with stage 2 empty
        wm_start = 1'b1;
        tick();
        wm_start = 1'b0;
        early_wds = 1'b1;
        tick();
        chk("R9 lockout pulse", lockout, 1'b1);
        tick();
        chk("R9 lockout one cycle", lockout, 1'b0);
        early_wds = 1'b0;
        tick();
        early_wds = 1'b1;
        tick();
        chk("R9 no lockout on later strobe", lockout, 1'b0);
        early_wds = 1'b0;
        buf2_full = 1'b1;
        wm_start = 1'b1;
        tick();
        wm_start = 1'b0;
        early_wds = 1'b1;
        tick();
        chk("R9 no lockout when stage 2 full", lockout, 1'b0);
        early_wds = 1'b0; buf2_full = 1'b0;
        do_reset();
        tick();

        // R5 write-side loss
        write_motion = 1'b1;
        wr_clk = 1'b1;
        tick();
        chk("R5 unbuffered legal end", lost_data, 1'b0);
        wr_clk = 1'b0; buf_mode = 1'b1; buf2_full = 1'b1;
        tick();
        wr_clk = 1'b1;
        tick();
        chk("R5 no loss with stage 2 full", lost_data, 1'b0);
        wr_clk = 1'b0; buf2_full = 1'b0;
        tick();
        wr_clk = 1'b1;
        tick();
        chk("R5 buffered write loss", lost_data, 1'b1);
        wr_clk = 1'b0; write_motion = 1'b0; buf_mode = 1'b0;

        // R6 sticky, R3 lost keeps request down
        repeat (3) tick();
        chk("R6 lost stays set", lost_data, 1'b1);
        raise_req();
        chk("R3 lost blocks req", data_req, 1'b0);
        xfer_pulse = 1'b0;
        do_reset();
        #1;
        chk("R6 reset clears lost", lost_data, 1'b0);
        tick();

        // R4 read-side loss
        read_motion = 1'b1; buf1_full = 1'b1;
        tape_rd_stb = 1'b1;
        tick();
        chk("R4 no loss without mode or last", lost_data, 1'b0);
        tape_rd_stb = 1'b0; last_word = 1'b1;
        tick();
        tape_rd_stb = 1'b1;
        tick();
        chk("R4 loss with last word", lost_data, 1'b1);
        tape_rd_stb = 1'b0; last_word = 1'b0;
        do_reset();
        buf_mode = 1'b1;
        tick();
        tape_rd_stb = 1'b1;
        tick();
        chk("R4 loss in buffered mode", lost_data, 1'b1);
        tape_rd_stb = 1'b0; buf_mode = 1'b0; read_motion = 1'b0; buf1_full = 1'b0;

        // R10 reset clears request too
        do_reset();
        raise_req();
        rst_n = 1'b0;
        tick();
        chk("R10 reset clears req", data_req, 1'b0);
        rst_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule